// File: doc/BRIEF.md
# Graphics Aperture Address Translator

The block sits on the inbound device path. It remaps bus addresses that land inside a programmable remapping window to 40-bit physical addresses. The window is a power-of-two multiple of 32 MB and sits on a 32 MB boundary below 4 GB. Each 4 KB page of the window is backed by one 32-bit entry in a table held inside the block. An entry packs physical address bits 31:12 together with bits 39:32, and carries a valid bit and a coherent bit.

Software programs the window control word, the window base and the table entries through a single write port. A separate strobe invalidates the whole table in one cycle. Devices present a bus address on the request port, and one clock later the response port returns the resulting address with three flags: hit, coherent and fault. An address outside the window passes through unchanged. So does every address while translation is switched off or the window is malformed.

Top module: `gart_xlat`

## Requirements
- R1: A request with `reqValid` high produces `rspValid` high exactly one clock later. With no request, `rspValid`, `rspHit`, `rspCoherent` and `rspFault` are low in the next cycle. A request uses the configuration as it stood before any write in the same cycle.
- R2: A write with `cfgSel`=0 loads the control word. Bit 0 enables translation, and bits [3:1] give an order n, so the window size is 32 MB << n.
- R3: A write with `cfgSel`=1 loads the window base. Bits [14:0] shifted left by 25 form the base, and bits [31:15] are ignored.
- R4: If base plus size exceeds 2^32, the window is disabled and the base is taken as zero. A window that ends exactly at 2^32 is usable.
- R5: While translation is disabled, or the window is invalid, every response has `rspAddr` = {8'h00, bus address} and all flags low.
- R6: A bus address below the base, or at or above base plus size, passes through unchanged with all flags low.
- R7: Inside the window, the table index is (address − base) >> 12. An entry is written with `cfgSel`=2 at index `cfgIdx`. Entry bit 0 means valid and bit 1 means coherent. The response is {entry[11:4], entry[31:12], address[11:0]} with `rspHit`=1, `rspCoherent`=entry bit 1 and `rspFault`=0.
- R8: Inside the window, an index whose entry has bit 0 clear, or an index at or beyond the table depth, gives `rspFault`=1, `rspHit`=0, `rspCoherent`=0, and the unchanged address.
- R9: `tblInv` clears the valid bit of every entry. If an entry write falls in the same cycle as the invalidate, the written entry takes effect after the clear.
- R10: A write with `cfgSel`=3 changes no state.
- R11: After reset, translation is off, every entry is invalid, and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Write target: 0 control, 1 base, 2 table entry, 3 none |
| cfgIdx | input | IDX_W | Table index for entry writes |
| cfgData | input | 32 | Configuration write data |
| tblInv | input | 1 | Invalidate all table entries |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 32 | Bus address to translate |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspAddr | output | 40 | Translated or passed-through address |
| rspHit | output | 1 | Address was translated through a valid entry |
| rspCoherent | output | 1 | Coherent bit of the hit entry |
| rspFault | output | 1 | In-window access to an invalid or missing entry |

## Verification
The assertions assume that a request address is stable only in the cycle it is presented. They check each response against the address from the cycle before, so the checks do not depend on `reqAddr` holding. They also assume the reset is held for at least one clock edge. The stimulus drives every input on the falling edge, one operation per cycle, and holds reset for several cycles. Random window bases and sizes often cross 4 GB, and random addresses are drawn mostly near the window's first 256 pages. This spread covers hits, faults, out-of-table indices and pass-through.

// File: rtl/gart_xlat_pkg.sv
package gart_xlat_pkg;

  localparam int BUS_W      = 32;
  localparam int PHYS_W     = 40;
  localparam int ENT_W      = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int APER_SHIFT = 25;
  localparam int ORDER_W    = 3;
  localparam int BASE_FLD_W = 15;
  localparam int FRAME_W    = PHYS_W - PAGE_SHIFT;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEntry;
    logic clrAll;
    logic look;
  } xlat_strobe_t;

  typedef struct packed {
    logic             active;
    logic [BUS_W-1:0] base;
    logic [BUS_W:0]   span;
  } xlat_window_t;

  typedef struct packed {
    logic               coh;
    logic [FRAME_W-1:0] frame;
  } tbl_entry_t;

  // unpack an entry word into a 40-bit page frame and the coherent bit
  function automatic tbl_entry_t unpackEntry(input logic [ENT_W-1:0] w);
    tbl_entry_t e;
    e.coh   = w[1];
    e.frame = {w[11:4], w[31:12]};
    return e;
  endfunction

endpackage

// File: rtl/gart_xlat_ctrl.sv
module gart_xlat_ctrl
  import gart_xlat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgSel,
  input  logic [BASE_FLD_W-1:0] cfgLow,
  input  logic                  tblInv,
  input  logic                  reqValid,
  output xlat_strobe_t          strobe,
  output xlat_window_t          window
);

  localparam logic [PHYS_W:0] LIMIT = (PHYS_W+1)'(1) << BUS_W;

  logic                  enReg;
  logic [ORDER_W-1:0]    orderReg;
  logic [BASE_FLD_W-1:0] baseFld;
  logic                  wrCtrl;
  logic                  wrBase;

  always_comb begin
    wrCtrl         = cfgWe && (cfgSel == SEL_CTRL);
    wrBase         = cfgWe && (cfgSel == SEL_BASE);
    strobe.wrEntry = cfgWe && (cfgSel == SEL_ENTRY);
    strobe.clrAll  = tblInv;
    strobe.look    = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      orderReg <= '0;
      baseFld  <= '0;
    end else begin
      if (wrCtrl) begin
        enReg    <= cfgLow[0];
        orderReg <= cfgLow[ORDER_W:1];
      end
      if (wrBase) baseFld <= cfgLow;
    end
  end

  logic [PHYS_W-1:0] apBase;
  logic [BUS_W:0]    apSpan;
  logic [PHYS_W:0]   apEnd;
  logic              fits;

  always_comb begin
    apBase = PHYS_W'(baseFld) << APER_SHIFT;
    apSpan = (BUS_W+1)'(1) << (APER_SHIFT + int'(orderReg));
    apEnd  = {1'b0, apBase} + (PHYS_W+1)'(apSpan);
    fits   = (apEnd <= LIMIT) && (apSpan != '0);
    window.active = enReg && fits;
    window.base   = fits ? apBase[BUS_W-1:0] : '0;
    window.span   = apSpan;
  end

  logic unusedCfgBits;
  assign unusedCfgBits = ^cfgLow[BASE_FLD_W-1:ORDER_W+1];

endmodule

// File: rtl/gart_xlat_dp.sv
module gart_xlat_dp
  import gart_xlat_pkg::*;
#(
  parameter int TBL_DEPTH = 256,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlat_strobe_t       strobe,
  input  xlat_window_t       window,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [ENT_W-1:0]   cfgData,
  input  logic [BUS_W-1:0]   reqAddr,
  output logic               rspValid,
  output logic [PHYS_W-1:0]  rspAddr,
  output logic               rspHit,
  output logic               rspCoherent,
  output logic               rspFault
);

  localparam int PAGE_W = BUS_W - PAGE_SHIFT;

  tbl_entry_t           tblData [TBL_DEPTH];
  logic [TBL_DEPTH-1:0] tblValid;

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = strobe.wrEntry && (cfgIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)              tblValid[g] <= 1'b0;
      else if (sel)           tblValid[g] <= cfgData[0];
      else if (strobe.clrAll) tblValid[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (sel) tblData[g] <= unpackEntry(cfgData);
    end
  end

  logic unusedEntBits;
  assign unusedEntBits = ^cfgData[3:2];

  // lookup
  logic [BUS_W-1:0]  offs;
  logic [PAGE_W-1:0] pageNo;
  logic [IDX_W-1:0]  idx;
  logic              inWin;
  logic              inTbl;
  tbl_entry_t        ent;
  logic              entOk;

  always_comb begin
    offs   = reqAddr - window.base;
    pageNo = offs[BUS_W-1:PAGE_SHIFT];
    idx    = pageNo[IDX_W-1:0];
    inWin  = window.active && (reqAddr >= window.base) &&
             ({1'b0, offs} < window.span);
    inTbl  = (pageNo >> IDX_W) == '0;
    ent    = tblData[idx];
    entOk  = tblValid[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspAddr     <= '0;
      rspHit      <= 1'b0;
      rspCoherent <= 1'b0;
      rspFault    <= 1'b0;
    end else begin
      rspValid    <= strobe.look;
      rspHit      <= 1'b0;
      rspCoherent <= 1'b0;
      rspFault    <= 1'b0;
      if (strobe.look) begin
        rspAddr <= PHYS_W'(reqAddr);
        if (inWin) begin
          if (inTbl && entOk) begin
            rspAddr     <= {ent.frame, reqAddr[PAGE_SHIFT-1:0]};
            rspHit      <= 1'b1;
            rspCoherent <= ent.coh;
          end else begin
            rspFault    <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/gart_xlat.sv
module gart_xlat
  import gart_xlat_pkg::*;
#(
  parameter int TBL_DEPTH = 256,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic              tblInv,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  output logic              rspValid,
  output logic [39:0]       rspAddr,
  output logic              rspHit,
  output logic              rspCoherent,
  output logic              rspFault
);

  xlat_strobe_t strobe;
  xlat_window_t window;

  gart_xlat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgLow   (cfgData[BASE_FLD_W-1:0]),
    .tblInv   (tblInv),
    .reqValid (reqValid),
    .strobe   (strobe),
    .window   (window)
  );

  gart_xlat_dp #(.TBL_DEPTH(TBL_DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .window      (window),
    .cfgIdx      (cfgIdx),
    .cfgData     (cfgData),
    .reqAddr     (reqAddr),
    .rspValid    (rspValid),
    .rspAddr     (rspAddr),
    .rspHit      (rspHit),
    .rspCoherent (rspCoherent),
    .rspFault    (rspFault)
  );

endmodule

// File: rtl/gart_xlat_chk.sv
module gart_xlat_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        rspValid,
  input logic [39:0] rspAddr,
  input logic        rspHit,
  input logic        rspCoherent,
  input logic        rspFault
);

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspHit && !rspCoherent && !rspFault));

  a_r5_pass_unchanged: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspAddr == {8'h00, $past(reqAddr)}));

  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAddr[11:0] == $past(reqAddr[11:0])));

  a_r7_coh_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    rspCoherent |-> rspHit);

  a_r8_hit_fault_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(rspHit && rspFault));

endmodule

bind gart_xlat gart_xlat_chk u_chk (.*);

// File: tb/gart_xlat_tb.sv
`timescale 1ns/1ps
module gart_xlat_tb;

  localparam int DEPTH = 256;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [1:0]       cfgSel = '0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [31:0]      cfgData = '0;
  logic             tblInv = 1'b0;
  logic             reqValid = 1'b0;
  logic [31:0]      reqAddr = '0;
  logic             rspValid;
  logic [39:0]      rspAddr;
  logic             rspHit;
  logic             rspCoherent;
  logic             rspFault;

  always #10 clk = ~clk;

  gart_xlat #(.TBL_DEPTH(DEPTH)) u_dut (.*);

  int          nRun = 0;
  int          nFail = 0;
  bit          done = 0;
  logic [3:0]  mCtrl = '0;
  logic [14:0] mBase = '0;
  logic [31:0] mEnt [DEPTH];
  logic        mValid [DEPTH];

  function automatic logic [42:0] expectRsp(input logic [31:0] a);
    logic [40:0] base, span;
    logic        ok, inW;
    int          idx;
    base = 41'(mBase) << 25;
    span = 41'(1) << (25 + int'(mCtrl[3:1]));
    ok   = mCtrl[0] && (base + span <= 41'h1_0000_0000);
    inW  = ok && (41'(a) >= base) && (41'(a) < base + span);
    if (!inW) return {3'b000, 8'h00, a};
    idx = int'((41'(a) - base) >> 12);
    if (idx >= DEPTH || !mValid[idx]) return {3'b001, 8'h00, a};
    return {1'b1, mEnt[idx][1], 1'b0, mEnt[idx][11:4], mEnt[idx][31:12], a[11:0]};
  endfunction

  task automatic check(input string tag, input logic [42:0] got, input logic [42:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfgWrite(input logic we, input logic [1:0] sel, input int idx,
                          input logic [31:0] data, input logic inv);
    @(negedge clk);
    cfgWe = we; cfgSel = sel; cfgIdx = IDX_W'(idx); cfgData = data; tblInv = inv;
    if (inv) for (int i = 0; i < DEPTH; i++) mValid[i] = 1'b0;
    if (we) begin
      case (sel)
        2'd0: mCtrl = data[3:0];
        2'd1: mBase = data[14:0];
        2'd2: begin mEnt[idx] = data; mValid[idx] = data[0]; end
        default: ;
      endcase
    end
    @(negedge clk);
    cfgWe = 1'b0; tblInv = 1'b0;
  endtask

  task automatic request(input logic [31:0] a, input string tag);
    logic [42:0] e;
    e = expectRsp(a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R1 valid"}, {42'd0, rspValid}, 43'd1);
    check(tag, {rspHit, rspCoherent, rspFault, rspAddr}, e);
  endtask

  function automatic logic [31:0] baseAddr();
    return 32'(mBase) << 25;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin mEnt[i] = '0; mValid[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {rspValid, rspHit, rspCoherent, rspFault, rspAddr[38:0]},
          {rspValid, 42'd0} & 43'd0);
    request(32'h1234_5678, "R5 disabled pass");

    // R3: upper bits ignored; base = 0x2000_0000; R2: enable, order 1 (64 MB)
    cfgWrite(1, 2'd1, 0, 32'hFFFF_0010, 0);
    cfgWrite(1, 2'd0, 0, 32'h0000_0003, 0);
    cfgWrite(1, 2'd2, 0, 32'hABCDE_5A3, 0);
    cfgWrite(1, 2'd2, 1, 32'h12345_0F1, 0);
    cfgWrite(1, 2'd2, 2, 32'h11111_002, 0);
    b = baseAddr();
    check("R3 base field", {11'd0, b}, {11'd0, 32'h2000_0000});
    request(b + 32'h0ABC, "R7 coherent hit");
    request(b + 32'h1FFF, "R7 plain hit");
    request(b + 32'h2000, "R8 invalid entry");
    request(b + 32'(DEPTH * 4096), "R8 beyond depth");
    request(b - 32'd4, "R6 below window");
    request(b + 32'h0400_0000, "R6 above window");
    request(b + 32'h03FF_FFFF, "R8 last page of window");

    // R1: idle cycle after a response
    @(negedge clk);
    check("R1 idle", {39'd0, rspValid, rspHit, rspCoherent, rspFault}, 43'd0);

    // R10: reserved target
    cfgWrite(1, 2'd3, 0, 32'h0000_0000, 0);
    request(b + 32'h0ABC, "R10 ignored write");

    // R4: window ending exactly at 4 GB, then crossing it
    cfgWrite(1, 2'd0, 0, 32'h0000_0005, 0);
    cfgWrite(1, 2'd1, 0, 32'h0000_007C, 0);
    request(32'hF800_0010, "R4 end at 4GB");
    cfgWrite(1, 2'd1, 0, 32'h0000_007D, 0);
    request(32'hFA00_0010, "R4 crossing disabled");
    request(32'h0000_0010, "R4 base forced zero");

    // R2: enable clear
    cfgWrite(1, 2'd1, 0, 32'h0000_0010, 0);
    cfgWrite(1, 2'd0, 0, 32'h0000_0004, 0);
    request(32'h2000_0123, "R2 enable off");
    cfgWrite(1, 2'd0, 0, 32'h0000_0001, 0);
    request(32'h2000_0123, "R2 order 0 hit");

    // R9: invalidate, then invalidate with a simultaneous write
    cfgWrite(0, 2'd0, 0, 32'h0, 1);
    request(32'h2000_0123, "R9 after invalidate");
    cfgWrite(1, 2'd2, 1, 32'h12345_0F1, 0);
    cfgWrite(1, 2'd2, 0, 32'h55555_7F3, 1);
    request(32'h2000_0456, "R9 write wins");
    request(32'h2000_1456, "R9 others cleared");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) cfgWrite(1, 2'd0, 0, ($urandom & 32'hFFFF_FFF0) | 32'(($urandom % 8) << 1) | 32'(($urandom % 8) != 0), 0);
      else if (r == 1) cfgWrite(1, 2'd1, 0, ($urandom & 32'hFFFF_8000) | ($urandom % 128), 0);
      else if (r <= 4) cfgWrite(1, 2'd2, int'($urandom % DEPTH), $urandom, 0);
      else if (r == 5 && ($urandom % 8) == 0) cfgWrite(($urandom % 2) == 1, 2'd2, int'($urandom % DEPTH), $urandom, 1);
      else if (r == 6) cfgWrite(1, 2'd3, 0, $urandom, 0);
      else begin
        logic [31:0] a;
        if (($urandom % 4) == 0) a = $urandom;
        else a = baseAddr() + 32'(($urandom % (DEPTH + 8)) << 12) + ($urandom % 4096);
        request(a, "R7 R8 random");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule